// File: doc/BRIEF.md
# Exception Entry and Return Frame Sequencer

This block carries out the stack traffic that a 32-bit processor needs when it enters an exception handler and when it returns from one. When it is idle it accepts one of three requests: a software exception with an index, a hardware interrupt with a level and a vector, or a return-from-exception. For an entry it aligns the supervisor stack pointer to a 4-byte boundary and pushes a two-longword frame (the return address, then a format longword). It then raises the status register to supervisor state and reads the handler address from a vector table. For a return it pops the same frame and restores the stack pointer, the status register and the program counter.

The core supplies its current PC, status register, supervisor stack pointer and vector base as plain inputs. The supervisor stack pointer is the one in use for all frame traffic. The sequencer reaches memory through a 32-bit big-endian request/response port with one access outstanding at a time. When the work is finished it raises a one-cycle `done` pulse. In that cycle the new PC, SR and SP are on `pc_out`, `sr_out` and `sp_out`, and they stay there until the next `done`.

Top module: `exc_frame_seq`

## Requirements
- R1: When idle, a return request has priority over a software exception, and a software exception has priority over an interrupt. An interrupt is taken only when `irq_lvl` is strictly greater than the mask field SR[10:8]. When an interrupt is taken, `irq_vec` becomes the exception index.
- R2: `busy` rises in the cycle after a request is taken and stays high until the cycle of `done`. Requests that arrive while `busy` is high are ignored.
- R3: The return address pushed on entry is PC+2 when the index lies in the trap window [TRAP_BASE, TRAP_BASE+TRAP_NUM-1] (default 32..47), and PC otherwise.
- R4: The format longword has bits 31:30 = 01, bits 29:28 = the two low bits of the stack pointer before alignment, bits 27:16 = index*4 zero-extended, and bits 15:0 = the status register as it was before entry.
- R5: On entry A = SP with bits 1:0 cleared. The first write stores the return address at A-4 and the second write stores the format longword at A-8. `sp_out` becomes A-8.
- R6: The entry SR has the supervisor bit (bit 13) set. For a hardware interrupt only, bits 10:8 take `irq_lvl` and the master bit (bit 12) is cleared. All other bits are kept.
- R7: After the two pushes the sequencer reads the word at `vbr` + index*4, and that word becomes `pc_out`.
- R8: On return the sequencer reads the format longword at SP and then the PC at SP+4. `sp_out` = (SP OR format[29:28]) + 8 and `sr_out` = format[15:0].
- R9: A memory request keeps its address, write enable and data stable until `mem_req_ready`. No new request is issued before the response of the previous one.
- R10: `done` is high for exactly one cycle per operation. `pc_out`, `sr_out` and `sp_out` change only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_req | input | 1 | Return-from-exception request |
| exc_req | input | 1 | Software exception request |
| exc_idx | input | IDX_W | Software exception index |
| irq_lvl | input | 3 | Pending interrupt level (0 = none) |
| irq_vec | input | IDX_W | Pending interrupt vector index |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 16 | Current status register |
| ssp_in | input | 32 | Supervisor stack pointer |
| vbr | input | 32 | Vector table base address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| pc_out | output | 32 | New program counter |
| sr_out | output | 16 | New status register |
| sp_out | output | 32 | New supervisor stack pointer |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench uses the default parameters IDX_W=8, TRAP_BASE=32 and TRAP_NUM=16. These values put indices 31, 32, 47 and 48 within reach, so both edges of the trap window are exercised. They also let every vector slot of a 128-entry table fit in a 1 KB memory model, next to the stack region. Its stack pointers include all four low-bit patterns, so the frame's alignment field and its recovery on return are both covered. One entry runs with a ready signal that drops on alternate cycles, to stress the request-hold rule.

// File: rtl/efs_pkg.sv
package efs_pkg;
  localparam int WORD_W   = 32;
  localparam int SRW      = 16;
  localparam int SR_S     = 13;
  localparam int SR_M     = 12;
  localparam int SR_I_HI  = 10;
  localparam int SR_I_LO  = 8;
  localparam int LVL_W    = SR_I_HI - SR_I_LO + 1;
  localparam int VOFF_W   = 12;
  localparam logic [1:0] FRAME_TAG = 2'b01;

  typedef enum logic [1:0] {K_EXC, K_IRQ, K_RET} kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_PUSH_RA, ST_PUSH_FMT, ST_VEC, ST_POP_FMT, ST_POP_PC} st_e;
  typedef enum logic [1:0] {P_IDLE, P_REQ, P_WAIT} ph_e;

  function automatic logic [VOFF_W-1:0] vec_offset(input logic [VOFF_W-1:0] n);
    return n << 2;
  endfunction

  function automatic logic [WORD_W-1:0] pack_frame(input logic [1:0] sp_lo,
                                                   input logic [VOFF_W-1:0] voff,
                                                   input logic [SRW-1:0] sr);
    return {FRAME_TAG, sp_lo, voff, sr};
  endfunction

  function automatic logic [SRW-1:0] enter_sr(input logic [SRW-1:0] sr, input logic hw,
                                              input logic [LVL_W-1:0] lvl);
    logic [SRW-1:0] r;
    r = sr;
    r[SR_S] = 1'b1;
    if (hw) begin
      r[SR_M] = 1'b0;
      r[SR_I_HI:SR_I_LO] = lvl;
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] unwind_sp(input logic [WORD_W-1:0] sp, input logic [1:0] lo);
    return (sp | {{(WORD_W-2){1'b0}}, lo}) + WORD_W'(8);
  endfunction
endpackage

// File: rtl/efs_accept.sv
module efs_accept import efs_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic             idle,
  input  logic             ret_req,
  input  logic             exc_req,
  input  logic [IDX_W-1:0] exc_idx,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [IDX_W-1:0] irq_vec,
  input  logic [LVL_W-1:0] cur_mask,
  output logic             take,
  output kind_e            take_kind,
  output logic [IDX_W-1:0] take_idx
);
  logic irq_above;

  always_comb begin
    irq_above = irq_lvl > cur_mask;
    take      = 1'b0;
    take_kind = K_EXC;
    take_idx  = exc_idx;
    if (idle) begin
      if (ret_req) begin
        take      = 1'b1;
        take_kind = K_RET;
      end else if (exc_req) begin
        take      = 1'b1;
        take_kind = K_EXC;
      end else if (irq_above) begin
        take      = 1'b1;
        take_kind = K_IRQ;
        take_idx  = irq_vec;
      end
    end
  end
endmodule

// File: rtl/efs_frame.sv
module efs_frame import efs_pkg::*; #(
  parameter int IDX_W     = 8,
  parameter int TRAP_BASE = 32,
  parameter int TRAP_NUM  = 16
) (
  input  kind_e              kind,
  input  logic [IDX_W-1:0]   idx,
  input  logic [WORD_W-1:0]  pc,
  input  logic [SRW-1:0]     sr,
  input  logic [WORD_W-1:0]  sp,
  input  logic [WORD_W-1:0]  vbase,
  input  logic [LVL_W-1:0]   lvl,
  output logic [WORD_W-1:0]  ra_addr,
  output logic [WORD_W-1:0]  ra_val,
  output logic [WORD_W-1:0]  fmt_addr,
  output logic [WORD_W-1:0]  fmt_val,
  output logic [WORD_W-1:0]  vec_addr,
  output logic [SRW-1:0]     new_sr,
  output logic [WORD_W-1:0]  new_sp
);
  localparam int TRAP_END = TRAP_BASE + TRAP_NUM;

  logic              is_trap;
  logic [WORD_W-1:0] base;
  logic [VOFF_W-1:0] voff;

  generate
    if (TRAP_NUM > 0) begin : g_trap
      assign is_trap = (WORD_W'(idx) >= WORD_W'(TRAP_BASE)) && (WORD_W'(idx) < WORD_W'(TRAP_END));
    end else begin : g_no_trap
      assign is_trap = 1'b0;
    end
  endgenerate

  always_comb begin
    base     = sp & ~WORD_W'(3);
    voff     = vec_offset(VOFF_W'(idx));
    ra_addr  = base - WORD_W'(4);
    fmt_addr = base - WORD_W'(8);
    ra_val   = is_trap ? pc + WORD_W'(2) : pc;
    fmt_val  = pack_frame(sp[1:0], voff, sr);
    vec_addr = vbase + WORD_W'(voff);
    new_sr   = enter_sr(sr, kind == K_IRQ, lvl);
    new_sp   = fmt_addr;
  end
endmodule

// File: rtl/efs_memif.sv
module efs_memif import efs_pkg::*; #(
  parameter int AW = WORD_W,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_start,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic          acc_idle,
  output logic          acc_done,
  output logic [DW-1:0] acc_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rdata
);
  ph_e phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (phase)
        P_IDLE: if (acc_start) begin
          phase     <= P_REQ;
          mem_we    <= acc_we;
          mem_addr  <= acc_addr;
          mem_wdata <= acc_wdata;
        end
        P_REQ:  if (mem_req_ready) phase <= P_WAIT;
        P_WAIT: if (mem_rsp_valid) phase <= P_IDLE;
        default: phase <= P_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (phase == P_REQ);
  assign acc_idle      = (phase == P_IDLE);
  assign acc_done      = (phase == P_WAIT) && mem_rsp_valid;
  assign acc_rdata     = mem_rdata;

  // R9: a stalled request holds its fields
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R9: an accepted request is not followed by another until a response arrives
  a_r9_one_out: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq import efs_pkg::*; #(
  parameter int IDX_W     = 8,
  parameter int TRAP_BASE = 32,
  parameter int TRAP_NUM  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_req,
  input  logic              exc_req,
  input  logic [IDX_W-1:0]  exc_idx,
  input  logic [2:0]        irq_lvl,
  input  logic [IDX_W-1:0]  irq_vec,
  input  logic [31:0]       cur_pc,
  input  logic [15:0]       cur_sr,
  input  logic [31:0]       ssp_in,
  input  logic [31:0]       vbr,
  output logic              busy,
  output logic              done,
  output logic [31:0]       pc_out,
  output logic [15:0]       sr_out,
  output logic [31:0]       sp_out,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rdata
);
  st_e               state;
  kind_e             c_kind, take_kind;
  logic [IDX_W-1:0]  c_idx, take_idx;
  logic [WORD_W-1:0] c_pc, c_sp, c_vbr;
  logic [SRW-1:0]    c_sr, c_fsr;
  logic [1:0]        c_flo;
  logic [LVL_W-1:0]  c_lvl;
  logic              take;

  logic              acc_start, acc_we, acc_idle, acc_done;
  logic [WORD_W-1:0] acc_addr, acc_wdata, acc_rdata;

  logic [WORD_W-1:0] f_ra_addr, f_ra, f_fmt_addr, f_fmt, f_vec_addr, f_new_sp;
  logic [SRW-1:0]    f_new_sr;

  efs_accept #(.IDX_W(IDX_W)) u_accept (
    .idle(state == ST_IDLE), .ret_req(ret_req), .exc_req(exc_req), .exc_idx(exc_idx),
    .irq_lvl(irq_lvl), .irq_vec(irq_vec), .cur_mask(cur_sr[SR_I_HI:SR_I_LO]),
    .take(take), .take_kind(take_kind), .take_idx(take_idx));

  efs_frame #(.IDX_W(IDX_W), .TRAP_BASE(TRAP_BASE), .TRAP_NUM(TRAP_NUM)) u_frame (
    .kind(c_kind), .idx(c_idx), .pc(c_pc), .sr(c_sr), .sp(c_sp), .vbase(c_vbr), .lvl(c_lvl),
    .ra_addr(f_ra_addr), .ra_val(f_ra), .fmt_addr(f_fmt_addr), .fmt_val(f_fmt),
    .vec_addr(f_vec_addr), .new_sr(f_new_sr), .new_sp(f_new_sp));

  efs_memif u_memif (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_idle(acc_idle), .acc_done(acc_done), .acc_rdata(acc_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rdata(mem_rdata));

  assign busy      = (state != ST_IDLE);
  assign acc_start = busy && acc_idle;

  always_comb begin
    acc_we    = 1'b0;
    acc_addr  = f_vec_addr;
    acc_wdata = f_ra;
    case (state)
      ST_PUSH_RA:  begin acc_we = 1'b1; acc_addr = f_ra_addr;  acc_wdata = f_ra;  end
      ST_PUSH_FMT: begin acc_we = 1'b1; acc_addr = f_fmt_addr; acc_wdata = f_fmt; end
      ST_VEC:      acc_addr = f_vec_addr;
      ST_POP_FMT:  acc_addr = c_sp;
      ST_POP_PC:   acc_addr = c_sp + WORD_W'(4);
      default:     acc_addr = f_vec_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      c_kind <= K_EXC;
      c_idx  <= '0;
      c_pc   <= '0;
      c_sr   <= '0;
      c_sp   <= '0;
      c_vbr  <= '0;
      c_lvl  <= '0;
      c_fsr  <= '0;
      c_flo  <= '0;
      done   <= 1'b0;
      pc_out <= '0;
      sr_out <= '0;
      sp_out <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (take) begin
          c_kind <= take_kind;
          c_idx  <= take_idx;
          c_pc   <= cur_pc;
          c_sr   <= cur_sr;
          c_sp   <= ssp_in;
          c_vbr  <= vbr;
          c_lvl  <= irq_lvl;
          state  <= (take_kind == K_RET) ? ST_POP_FMT : ST_PUSH_RA;
        end
        ST_PUSH_RA:  if (acc_done) state <= ST_PUSH_FMT;
        ST_PUSH_FMT: if (acc_done) state <= ST_VEC;
        ST_VEC: if (acc_done) begin
          pc_out <= acc_rdata;
          sr_out <= f_new_sr;
          sp_out <= f_new_sp;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        ST_POP_FMT: if (acc_done) begin
          c_fsr <= acc_rdata[SRW-1:0];
          c_flo <= acc_rdata[29:28];
          state <= ST_POP_PC;
        end
        ST_POP_PC: if (acc_done) begin
          pc_out <= acc_rdata;
          sr_out <= c_fsr;
          sp_out <= unwind_sp(c_sp, c_flo);
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a taken request makes the block busy in the next cycle
  a_r2_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy);
  // R2: busy only ends through a completion
  a_r2_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R1: an interrupt at or below the mask does not start work
  a_r1_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !ret_req && !exc_req && (irq_lvl <= cur_sr[SR_I_HI:SR_I_LO]) |=> !busy);
  // R10: single-cycle completion strobe
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: results move only with a completion
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pc_out) && $stable(sr_out) && $stable(sp_out));
  // R6: every entry ends in supervisor state
  a_r6_super: assert property (@(posedge clk) disable iff (!rst_n)
    done && (c_kind != K_RET) |-> sr_out[SR_S]);
  // R6: interrupts take the level and drop the master bit
  a_r6_irq_sr: assert property (@(posedge clk) disable iff (!rst_n)
    done && (c_kind == K_IRQ) |-> !sr_out[SR_M] && (sr_out[SR_I_HI:SR_I_LO] == c_lvl));
  // R5: the entry stack pointer is word aligned
  a_r5_align: assert property (@(posedge clk) disable iff (!rst_n)
    done && (c_kind != K_RET) |-> sp_out[1:0] == 2'b00);
endmodule

// File: tb/sim_exc_frame_seq.sv
`timescale 1ns/1ps
module sim_exc_frame_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_req = 1'b0, exc_req = 1'b0;
  logic [7:0]  exc_idx = '0, irq_vec = '0;
  logic [2:0]  irq_lvl = '0;
  logic [31:0] cur_pc = '0, ssp_in = '0, vbr = 32'h200;
  logic [15:0] cur_sr = '0;
  logic        busy, done, mem_req_valid, mem_we, mem_rsp_valid, mem_req_ready;
  logic [31:0] pc_out, sp_out, mem_addr, mem_wdata, mem_rdata;
  logic [15:0] sr_out;

  logic        stall = 1'b0, tog = 1'b0;
  logic [31:0] bmem [256];
  logic [31:0] wlog0, wlog1;
  int          total = 0, bad = 0, cyc = 0;
  bit          ended = 1'b0;

  always #2.5 clk = ~clk;

  exc_frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .exc_req(exc_req), .exc_idx(exc_idx),
    .irq_lvl(irq_lvl), .irq_vec(irq_vec), .cur_pc(cur_pc), .cur_sr(cur_sr), .ssp_in(ssp_in),
    .vbr(vbr), .busy(busy), .done(done), .pc_out(pc_out), .sr_out(sr_out), .sp_out(sp_out),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rdata(mem_rdata));

  function automatic logic [31:0] vt(input int i);
    return 32'hA000_0000 + 32'(i) * 32'h10;
  endfunction

  assign mem_req_ready = stall ? tog : 1'b1;

  always @(posedge clk) begin
    tog <= ~tog;
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bmem[i] <= (i >= 128) ? vt(i - 128) : 32'h0;
      wlog0 <= '0;
      wlog1 <= '0;
    end else if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rdata     <= bmem[mem_addr[9:2]];
      if (mem_we) begin
        bmem[mem_addr[9:2]] <= mem_wdata;
        wlog1 <= wlog0;
        wlog0 <= mem_addr;
      end
    end
  end

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung act=%0d exp=<100000", cyc);
      summary();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_fmt(input logic [31:0] sp, input logic [7:0] idx, input logic [15:0] sr);
    logic [31:0] f;
    f = 32'h4000_0000;
    f[29:28] = sp[1:0];
    f[27:16] = {2'b00, idx, 2'b00};
    f[15:0]  = sr;
    return f;
  endfunction

  function automatic logic [15:0] exp_sr(input logic [15:0] sr, input bit hw, input logic [2:0] lvl);
    logic [15:0] s;
    s = sr;
    if (hw) s = (s & 16'hE8FF) | {5'b0, lvl, 8'h00};
    return s | 16'h2000;
  endfunction

  task automatic issue(input bit ret, input bit hw, input logic [7:0] idx, input logic [31:0] pc,
                       input logic [15:0] sr, input logic [31:0] sp, input logic [2:0] lvl);
    @(negedge clk);
    ret_req = ret;
    exc_req = !ret && !hw;
    exc_idx = idx;
    irq_vec = idx;
    irq_lvl = hw ? lvl : 3'd0;
    cur_pc  = pc;
    cur_sr  = sr;
    ssp_in  = sp;
    @(negedge clk);
    ret_req = 1'b0;
    exc_req = 1'b0;
    irq_lvl = 3'd0;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    check({tag, " R10 done seen"}, {31'b0, done}, 32'd1);
  endtask

  task automatic check_pulse(input string tag);
    logic [31:0] p;
    p = pc_out;
    @(negedge clk);
    check({tag, " R10 done one cycle"}, {31'b0, done}, 32'd0);
    check({tag, " R10 pc held"}, pc_out, p);
  endtask

  task automatic entry_and_return(input bit hw, input logic [7:0] idx, input logic [31:0] pc,
                                  input logic [15:0] sr, input logic [31:0] sp, input logic [2:0] lvl);
    logic [31:0] a, ra;
    a  = sp & ~32'd3;
    ra = (idx >= 8'd32 && idx <= 8'd47) ? pc + 32'd2 : pc;
    issue(1'b0, hw, idx, pc, sr, sp, lvl);
    check("R2 busy after take", {31'b0, busy}, 32'd1);
    wait_done("entry");
    check("R3 return address", bmem[(a - 32'd4) >> 2], ra);
    check("R4 format word", bmem[(a - 32'd8) >> 2], exp_fmt(sp, idx, sr));
    check("R5 first push addr", wlog1, a - 32'd4);
    check("R5 second push addr", wlog0, a - 32'd8);
    check("R5 new sp", sp_out, a - 32'd8);
    check("R6 new sr", {16'b0, sr_out}, {16'b0, exp_sr(sr, hw, lvl)});
    check("R7 handler pc", pc_out, vt(int'(idx)));
    check_pulse("entry");
    issue(1'b1, 1'b0, 8'd0, 32'h0, exp_sr(sr, hw, lvl), a - 32'd8, 3'd0);
    wait_done("return");
    check("R8 restored pc", pc_out, ra);
    check("R8 restored sr", {16'b0, sr_out}, {16'b0, sr});
    check("R8 restored sp", sp_out, sp);
  endtask

  localparam int NV = 8;
  localparam bit          T_HW  [NV] = '{0, 0, 0, 0, 0, 1, 1, 0};
  localparam logic [7:0]  T_IDX [NV] = '{8'd5, 8'd32, 8'd47, 8'd48, 8'd31, 8'd64, 8'd100, 8'd127};
  localparam logic [31:0] T_PC  [NV] = '{32'h1000, 32'h2000, 32'h3000, 32'h3100, 32'h3200,
                                         32'h4000, 32'h5000, 32'hFFFF_FFFE};
  localparam logic [15:0] T_SR  [NV] = '{16'h0004, 16'h0011, 16'h2700, 16'h0000, 16'h001F,
                                         16'h3204, 16'h0600, 16'h8000};
  localparam logic [31:0] T_SP  [NV] = '{32'h1F0, 32'h1E3, 32'h1D1, 32'h1C2, 32'h1B0,
                                         32'h180, 32'h177, 32'h143};
  localparam logic [2:0]  T_LVL [NV] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd5, 3'd7, 3'd0};

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R2 reset busy", {31'b0, busy}, 32'd0);
    check("R10 reset done", {31'b0, done}, 32'd0);
    check("R9 reset req", {31'b0, mem_req_valid}, 32'd0);
    check("R10 reset pc", pc_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      entry_and_return(T_HW[i], T_IDX[i], T_PC[i], T_SR[i], T_SP[i], T_LVL[i]);

    // R9: ready drops every other cycle
    stall = 1'b1;
    entry_and_return(1'b0, 8'd40, 32'h6000, 16'h0123, 32'h152, 3'd0);
    stall = 1'b0;

    // R1: level equal to mask is not taken
    @(negedge clk);
    cur_sr  = 16'h0500;
    irq_lvl = 3'd5;
    irq_vec = 8'd70;
    repeat (6) @(negedge clk);
    check("R1 masked irq keeps idle", {31'b0, busy}, 32'd0);
    check("R1 masked irq no memory", {31'b0, mem_req_valid}, 32'd0);
    irq_lvl = 3'd0;

    // R1: level above mask is taken and its vector used
    entry_and_return(1'b1, 8'd70, 32'h7000, 16'h0500, 32'h160, 3'd6);

    // R1: software exception beats a pending interrupt
    @(negedge clk);
    exc_req = 1'b1; exc_idx = 8'd6; irq_lvl = 3'd7; irq_vec = 8'd90;
    cur_pc = 32'h8000; cur_sr = 16'h0000; ssp_in = 32'h170;
    @(negedge clk);
    exc_req = 1'b0; irq_lvl = 3'd0;
    wait_done("prio");
    check("R1 exception over irq pc", pc_out, vt(6));
    check("R1 exception over irq fmt", bmem[(32'h170 - 32'd8) >> 2], exp_fmt(32'h170, 8'd6, 16'h0000));

    // R1: return beats a software exception
    @(negedge clk);
    ret_req = 1'b1; exc_req = 1'b1; exc_idx = 8'd9; ssp_in = 32'h168; cur_sr = 16'h2000;
    @(negedge clk);
    ret_req = 1'b0; exc_req = 1'b0;
    wait_done("prio2");
    check("R1 return over exception sp", sp_out, 32'h170);
    check("R1 return over exception pc", pc_out, 32'h8000);

    // R2: a request while busy is ignored
    issue(1'b0, 1'b0, 8'd11, 32'h9000, 16'h0000, 32'h190, 3'd0);
    @(negedge clk);
    exc_req = 1'b1; exc_idx = 8'd12;
    @(negedge clk);
    exc_req = 1'b0;
    wait_done("busyign");
    check("R2 first request result", pc_out, vt(11));
    repeat (10) @(negedge clk);
    check("R2 busy request dropped", {31'b0, busy}, 32'd0);
    check("R2 outputs untouched", pc_out, vt(11));

    summary();
  end
endmodule